// File: doc/BRIEF.md
# Programmable memory pattern engine

This block is a memory controller core that software programs. It does not run a fixed state machine. A host loads a 64-word pattern RAM through a two-register bus. One register is the mode register and the other is the data register. The mode register selects one of four operations, and it also holds a 6-bit machine address that points into the RAM.

In the two array operations, every pulse on the access input moves one word between the data register and the RAM. The machine address then steps forward. In the run operation, the next access pulse starts execution at the machine address. The engine then plays one stored word per clock and drives the low bits of each word onto the strobe outputs. It stops after the word that carries the last-word flag.

Software ends a run session by writing the operation field back to normal. It then polls the mode register until the field reads as clear. A mode write that arrives while a pattern is playing is held back until the pattern finishes, so the poll only sees normal once the engine is idle.

Top module: `pattern_engine`

## Requirements
- R1: After reset, the operation field is normal, the machine address is 0, the data register is 0, busy_o is low and strb_o is 0.
- R2: Bus address 0 is the mode register and address 1 is the data register. In the mode register, the operation is in bits 29:28 (0 normal, 1 write array, 2 read array, 3 run) and the machine address is in bits 5:0. All other mode bits read as 0.
- R3: In write-array mode, an access pulse stores the data register into the RAM word at the machine address.
- R4: In read-array mode, an access pulse loads the RAM word at the machine address into the data register. The new value is readable on the following cycle.
- R5: After each write-array or read-array access, the machine address increases by one and wraps from 63 to 0.
- R6: In normal mode, an access pulse changes neither the machine address nor the data register, and it produces no strobes.
- R7: In run mode, an access pulse raises busy_o on the next cycle. Starting at the machine address, each busy cycle shows bits 3:0 of one RAM word on strb_o, in ascending address order, and the address wraps from 63 to 0.
- R8: Execution stops after the word with bit 31 set, and busy_o falls on the following cycle. While busy_o is low, strb_o is 0.
- R9: Access pulses that arrive while a pattern is playing are ignored. They do not restart the pattern and do not lengthen it.
- R10: A mode-register write that arrives while a pattern is playing takes effect when the pattern ends. Until then, reads of the mode register show the running operation. Data-register writes take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 1 | 0 selects the mode register, 1 selects the data register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register (combinational) |
| access_i | input | 1 | One-cycle access pulse that hits the block |
| strb_o | output | 4 | Strobe outputs driven by the current pattern word |
| busy_o | output | 1 | High while a pattern plays |

## Verification
The assertions assume the following about the inputs:
- access_i is never pulsed in the same cycle as a bus write, so a bus write and an array-step update never compete for the same register.
- Every pattern the bench runs contains a word with the last-word flag, so a run always ends.

The bench keeps within these limits in two ways. It drives bus cycles and access pulses from sequential tasks that never overlap. It also loads the RAM with flags at three known addresses before any run starts.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_NORMAL = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_RUN    = 2'd3
  } op_e;
endpackage

// File: rtl/pe_ram.sv
module pe_ram #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int STRB_W   = 4,
  parameter int LAST_BIT = 31
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [STRB_W-1:0] strb_b_o,
  output logic              last_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] word_b;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign word_b    = mem_q[raddr_b_i];
  assign strb_b_o  = word_b[STRB_W-1:0];
  assign last_b_o  = word_b[LAST_BIT];
endmodule

// File: rtl/pe_regs.sv
module pe_regs
  import pe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAD_W  = 6,
  parameter int OP_LSB = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              access_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output op_e               op_o,
  output logic [MAD_W-1:0]  mad_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic              ram_we_o,
  output logic              start_o,
  output logic [DATA_W-1:0] rdata_o
);
  op_e              op_q, pend_op_q;
  logic [MAD_W-1:0] mad_q, pend_mad_q;
  logic             pend_v_q;
  logic [DATA_W-1:0] mdr_q;

  logic mode_wr, data_wr, arr_wr, arr_rd, hold;
  op_e  wr_op;

  assign mode_wr = bus_en_i && bus_we_i && !bus_addr_i;
  assign data_wr = bus_en_i && bus_we_i &&  bus_addr_i;
  assign wr_op   = op_e'(bus_wdata_i[OP_LSB+1:OP_LSB]);
  assign arr_wr  = access_i && (op_q == OP_WRITE);
  assign arr_rd  = access_i && (op_q == OP_READ);
  assign start_o = access_i && (op_q == OP_RUN) && !busy_i;
  // a starting run counts as busy so the mode cannot move under it
  assign hold    = busy_i || start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_NORMAL;
      mad_q      <= '0;
      pend_op_q  <= OP_NORMAL;
      pend_mad_q <= '0;
      pend_v_q   <= 1'b0;
    end else if (mode_wr && !hold) begin
      op_q  <= wr_op;
      mad_q <= bus_wdata_i[MAD_W-1:0];
    end else if (mode_wr && done_i) begin
      op_q     <= wr_op;
      mad_q    <= bus_wdata_i[MAD_W-1:0];
      pend_v_q <= 1'b0;
    end else if (mode_wr) begin
      pend_op_q  <= wr_op;
      pend_mad_q <= bus_wdata_i[MAD_W-1:0];
      pend_v_q   <= 1'b1;
    end else if (done_i && pend_v_q) begin
      op_q     <= pend_op_q;
      mad_q    <= pend_mad_q;
      pend_v_q <= 1'b0;
    end else if (arr_wr || arr_rd) begin
      mad_q <= mad_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mdr_q <= '0;
    else if (data_wr) mdr_q <= bus_wdata_i;
    else if (arr_rd)  mdr_q <= arr_rdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (bus_addr_i) begin
      rdata_o = mdr_q;
    end else begin
      rdata_o[OP_LSB+1:OP_LSB] = op_q;
      rdata_o[MAD_W-1:0]       = mad_q;
    end
  end

  assign op_o     = op_q;
  assign mad_o    = mad_q;
  assign mdr_o    = mdr_q;
  assign ram_we_o = arr_wr;

  // R5
  mad_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr || arr_rd) && !mode_wr |=> mad_q == $past(mad_q) + 1'b1);

  // R10
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> op_q == $past(op_q));

  // R6
  normal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i && op_q == OP_NORMAL && !bus_en_i |=> $stable(mad_q) && $stable(mdr_q));
endmodule

// File: rtl/pe_seq.sv
module pe_seq #(
  parameter int ADDR_W = 6,
  parameter int STRB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [STRB_W-1:0] word_strb_i,
  input  logic              word_last_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STRB_W-1:0] strb_o
);
  logic [ADDR_W-1:0] pc_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      pc_q   <= start_addr_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      pc_q <= pc_q + 1'b1;
      if (word_last_i) busy_q <= 1'b0;
    end
  end

  assign pc_o   = pc_q;
  assign busy_o = busy_q;
  assign done_o = busy_q && word_last_i;
  assign strb_o = busy_q ? word_strb_i : '0;

  // R7
  run_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && pc_q == $past(start_addr_i));

  // R7
  word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !word_last_i |=> busy_q && pc_q == $past(pc_q) + 1'b1);

  // R8
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && word_last_i && !start_i |=> !busy_q);
endmodule

// File: rtl/pattern_engine.sv
module pattern_engine
  import pe_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAD_W    = 6,
  parameter int STRB_W   = 4,
  parameter int OP_LSB   = 28,
  parameter int LAST_BIT = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              access_i,
  output logic [STRB_W-1:0] strb_o,
  output logic              busy_o
);
  op_e               op;
  logic [MAD_W-1:0]  mad, pc;
  logic [DATA_W-1:0] mdr, arr_rdata;
  logic              ram_we, start, done, word_last;
  logic [STRB_W-1:0] word_strb;

  pe_regs #(.DATA_W(DATA_W), .MAD_W(MAD_W), .OP_LSB(OP_LSB)) u_regs (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .access_i,
    .busy_i     (busy_o),
    .done_i     (done),
    .arr_rdata_i(arr_rdata),
    .op_o       (op),
    .mad_o      (mad),
    .mdr_o      (mdr),
    .ram_we_o   (ram_we),
    .start_o    (start),
    .rdata_o    (bus_rdata_o)
  );

  pe_ram #(.DATA_W(DATA_W), .ADDR_W(MAD_W), .STRB_W(STRB_W), .LAST_BIT(LAST_BIT)) u_ram (
    .clk_i,
    .we_i      (ram_we),
    .waddr_i   (mad),
    .wdata_i   (mdr),
    .raddr_a_i (mad),
    .rdata_a_o (arr_rdata),
    .raddr_b_i (pc),
    .strb_b_o  (word_strb),
    .last_b_o  (word_last)
  );

  pe_seq #(.ADDR_W(MAD_W), .STRB_W(STRB_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i      (start),
    .start_addr_i (mad),
    .word_strb_i  (word_strb),
    .word_last_i  (word_last),
    .pc_o         (pc),
    .busy_o       (busy_o),
    .done_o       (done),
    .strb_o       (strb_o)
  );

  // R9
  busy_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> op == OP_RUN);

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && access_i && !done |=> busy_o && pc == $past(pc) + 1'b1);
endmodule

// File: tb/pattern_engine_tb.sv
module pattern_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          access = 1'b0;
  logic [3:0]    strb;
  logic          busy;

  int checks = 0, failures = 0, busy_cnt = 0;
  logic [3:0]    exp_q[$];
  logic [DW-1:0] exp_ram[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_engine u_dut (
    .clk_i(clk), .rst_ni, .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .access_i(access), .strb_o(strb), .busy_o(busy)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int i);
    logic [DW-1:0] h;
    h = (i + 1) * 32'h9E37_79B1;
    h[31] = (i == 1 || i == 10 || i == 40);
    return h;
  endfunction

  task automatic bus_wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
    #1;
    check(req, bus_rdata, exp);
    bus_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    access = 1'b1;
    @(negedge clk);
    access = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (busy) begin
        busy_cnt++;
        if (exp_q.size() == 0) begin
          failures++; checks++;
          $display("FAIL R8 actual=extra strobe %h expected=idle", strb);
        end else begin
          check("R7 strobe", {28'b0, strb}, {28'b0, exp_q.pop_front()});
        end
      end else if (strb !== 4'b0) begin
        failures++; checks++;
        $display("FAIL R8 actual=%h expected=0 while idle", strb);
      end
    end
  end

  task automatic run_from(input int s, input bool_extra);
    int i, n;
    i = s; n = 0;
    forever begin
      exp_q.push_back(exp_ram[i][3:0]);
      n++;
      if (exp_ram[i][31]) break;
      i = (i + 1) % 64;
    end
    bus_wr(1'b0, 32'h3000_0000 | s);
    busy_cnt = 0;
    pulse();
    check("R7 busy rises", {31'b0, busy}, 32'd1);
    if (bool_extra) pulse(); // R9 trigger while busy
    wait_idle();
    @(negedge clk);
    check("R8 run length", busy_cnt, n);
    check("R9 queue drained", exp_q.size(), 0);
    check("R8 busy low", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    bus_rd(1'b0, 32'h0, "R1 mode");
    bus_rd(1'b1, 32'h0, "R1 data");
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 strb", {28'b0, strb}, 32'd0);
    // R2: stray bits dropped
    bus_wr(1'b0, 32'hCF0F_0F05);
    bus_rd(1'b0, 32'h0000_0005, "R2 fields");
    bus_wr(1'b0, 32'h1000_0005);
    bus_rd(1'b0, 32'h1000_0005, "R2 write mode");
    // R3: load all words starting at 0
    bus_wr(1'b0, 32'h1000_0000);
    for (int i = 0; i < 64; i++) begin
      exp_ram[i] = word_of(i);
      bus_wr(1'b1, exp_ram[i]);
      pulse();
    end
    bus_rd(1'b0, 32'h1000_0000, "R5 wrap after 64");
    // R4
    bus_wr(1'b0, 32'h2000_003E);
    pulse();
    bus_rd(1'b1, exp_ram[62], "R4 read 62");
    bus_rd(1'b0, 32'h2000_003F, "R5 step");
    pulse();
    bus_rd(1'b1, exp_ram[63], "R3 R4 read 63");
    pulse();
    bus_rd(1'b1, exp_ram[0], "R3 R4 read 0 after wrap");
    bus_rd(1'b0, 32'h2000_0001, "R5 wrap");
    // R6
    bus_wr(1'b0, 32'h0000_0007);
    bus_wr(1'b1, 32'h0000_1234);
    pulse();
    bus_rd(1'b0, 32'h0000_0007, "R6 mad kept");
    bus_rd(1'b1, 32'h0000_1234, "R6 data kept");
    check("R6 no busy", {31'b0, busy}, 32'd0);
    // R7 R8 R9
    run_from(62, 1'b1);
    run_from(40, 1'b0);
    run_from(2, 1'b1);
    // R10: deferred mode write
    exp_q.push_back(exp_ram[5][3:0]);
    for (int i = 6; i <= 10; i++) exp_q.push_back(exp_ram[i][3:0]);
    bus_wr(1'b0, 32'h3000_0005);
    pulse();
    bus_wr(1'b0, 32'h0000_0000);
    bus_rd(1'b0, 32'h3000_0005, "R10 mode held");
    check("R10 still busy", {31'b0, busy}, 32'd1);
    bus_wr(1'b1, 32'h0000_CAFE);
    wait_idle();
    bus_rd(1'b0, 32'h0000_0000, "R10 mode applied");
    bus_rd(1'b1, 32'h0000_CAFE, "R10 data write");
    check("R10 queue drained", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule